// File: doc/BRIEF.md
# Cascadable Multi-Counter Watchdog Core

This core runs three counters in the low-frequency clock domain. Two of them are 16 bits wide and compare against a match value. The third is 32 bits wide. Its period is set by choosing which of its bits to watch for a toggle.

Each 16-bit counter has two ways to run. It can run free through its full range, with the match value setting the phase of its event. Or it can return to zero on each match, so that the match value sets the period. A lower counter can drive the counter above it. When a cascade select is set, the upper counter advances only on the lower counter's cascade event instead of on every clock.

Every counter has its own action mode, which decides what its event does: nothing, an interrupt pulse, a watchdog reset pulse, or interrupts that turn into a reset. In that last mode the reset comes once the interrupt has gone unserviced for three events.

Enable and clear requests come from a faster domain and pass through a short synchronizer. Firmware reads back the synchronized enable state to know when a counter is really running.

Top module: `mcw_core`

## Requirements
- R1: A change on `en_i[n]` reaches `en_stat_o[n]` after two clock edges. Counter n counts only while its synchronized enable is high. The first count comes on the third edge after `en_i` rises, and the last count comes on the second edge after it falls.
- R2: An enabled counter advances by exactly one on each of its ticks. A request on `clr_i[n]` is registered on one edge, and the count reads zero after the next edge. While the registered request is high, the count stays at zero and the counter emits no events, whatever ticks arrive. Every new request clears the counter again.
- R3: With clear-on-match off, a 16-bit counter wraps from 0xFFFF to 0. It fires its match event once per 65536 ticks, on the tick that leaves the match value, and keeps counting past the match.
- R4: With clear-on-match on, the match event fires on the tick taken while the count equals the match value. That tick returns the count to 0, so the period is match+1 ticks.
- R5: `casc_i[0]=1` makes counter 1 tick only on counter 0's cascade event, and `casc_i[1]=1` does the same for counter 2 from counter 1. A counter's cascade event is its match event when its clear-on-match is on, and its wrap event when it is off. With a select at 0, the counter ticks on every clock.
- R6: Counter 2 fires its event on each tick that toggles bit `tbit_i` of its count. That is every tick taken while the count's bits below `tbit_i` are all ones, which gives a period of 2^`tbit_i` ticks.
- R7: The mode codes for counters 0 and 1 are 0 = none, 1 = interrupt, 2 = reset, 3 = interrupt then reset. Counter 2 uses a single bit, where 0 = none and 1 = interrupt. In modes 1 and 3 an event drives `irq_o[n]` high for one cycle, just after the edge that takes the event. In modes 0 and 2 no interrupt is raised.
- R8: In mode 3, an event that arrives while `pend_i[n]` is high adds one to a strike count. The third such event pulses the reset and zeroes the count. Any cycle with `pend_i[n]` low zeroes the count.
- R9: `wdt_rst_o` is a one-cycle pulse. It comes after the edge of a counter's event, when that counter is in mode 2 or fires on its third strike in mode 3. It is the OR of all three counters.
- R10: After a synchronous reset, all counts, interrupt pulses, the reset pulse and all enable status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency counting clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 3 | Per-counter enable request (asynchronous) |
| clr_i | input | 3 | Per-counter clear request |
| match0_i | input | 16 | Match value of counter 0 |
| match1_i | input | 16 | Match value of counter 1 |
| clr_on_match_i | input | 2 | Clear-on-match for counters 0 and 1 |
| casc_i | input | 2 | Bit 0: counter 1 ticks from counter 0; bit 1: counter 2 ticks from counter 1 |
| mode0_i | input | 2 | Action mode of counter 0 |
| mode1_i | input | 2 | Action mode of counter 1 |
| mode2_i | input | 1 | Interrupt enable of counter 2 |
| tbit_i | input | 5 | Bit of counter 2 watched for a toggle |
| pend_i | input | 3 | Interrupt-pending feedback per counter |
| cnt0_o | output | 16 | Live count of counter 0 |
| cnt1_o | output | 16 | Live count of counter 1 |
| cnt2_o | output | 32 | Live count of counter 2 |
| irq_o | output | 3 | Per-counter interrupt pulses |
| wdt_rst_o | output | 1 | Watchdog reset pulse |
| en_stat_o | output | 3 | Synchronized enable status |

## Verification
Each counter's live count is an output, so a wrong increment, a missed clear or a bad wrap shows on the port after the very next edge. A wrong event decision has a longer reach. A bad match or toggle compare, or a cascade tick sent to the wrong counter, first moves a pulse by one or more whole periods; with cascading, it also shifts every count above it. A strike counter that is wrongly loaded, or not cleared while the interrupt is serviced, stays hidden until the next mode-3 event, when the reset pulse comes one or more events early or late. The scoreboard therefore records the exact cycle of every pulse, not just the order in which pulses arrive.

// File: rtl/mcw_pkg.sv
`timescale 1ns/1ps
package mcw_pkg;

    localparam int SHORT_W   = 16;
    localparam int LONG_W    = 32;
    localparam int N_SHORT   = 2;
    localparam int N_CTR     = N_SHORT + 1;
    localparam int STRIKES   = 3;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_IRQ     = 2'd1,
        ACT_RST     = 2'd2,
        ACT_IRQ_RST = 2'd3
    } act_mode_e;

    typedef struct packed {
        logic hit;    // match or toggle event of this counter
        logic carry;  // event handed to the counter above
    } ctr_evt_t;

    function automatic logic raises_irq(input act_mode_e m);
        return (m == ACT_IRQ) || (m == ACT_IRQ_RST);
    endfunction

endpackage

// File: rtl/mcw_sync.sv
`timescale 1ns/1ps
module mcw_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] en_async,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] en_run,
    output logic [N-1:0] clr_now
);
    logic [N-1:0] en_meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_meta <= '0;
            en_run  <= '0;
            clr_now <= '0;
        end else begin
            en_meta <= en_async;
            en_run  <= en_meta;
            clr_now <= clr_req;
        end
    end
endmodule

// File: rtl/mcw_match_ctr.sv
`timescale 1ns/1ps
module mcw_match_ctr
    import mcw_pkg::*;
#(
    parameter int W = SHORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         clr,
    input  logic         clr_on_match,
    input  logic [W-1:0] match,
    output logic [W-1:0] cnt,
    output ctr_evt_t     evt
);
    logic adv, hit, wrap;

    assign adv  = run && tick && !clr;
    assign hit  = adv && (cnt == match);
    assign wrap = adv && (&cnt);

    always_comb begin
        evt.hit   = hit;
        evt.carry = clr_on_match ? hit : wrap;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (hit && clr_on_match)
            cnt <= '0;
        else if (adv)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mcw_toggle_ctr.sv
`timescale 1ns/1ps
module mcw_toggle_ctr
    import mcw_pkg::*;
#(
    parameter int W  = LONG_W,
    localparam int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic          clr,
    input  logic [SW-1:0] sel,
    output logic [W-1:0]  cnt,
    output logic          hit
);
    logic          adv;
    logic [W-1:0]  low_mask;

    assign adv      = run && tick && !clr;
    assign low_mask = (W'(1) << sel) - W'(1);
    assign hit      = adv && ((cnt & low_mask) == low_mask);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (adv)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mcw_action.sv
`timescale 1ns/1ps
module mcw_action
    import mcw_pkg::*;
#(
    parameter int  LIMIT = STRIKES,
    localparam int CW    = $clog2(LIMIT + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      hit,
    input  act_mode_e mode,
    input  logic      pend,
    output logic      irq,
    output logic      wdt
);
    logic [CW-1:0] strikes;
    logic          last_strike;

    assign last_strike = (mode == ACT_IRQ_RST) && pend && (strikes == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            irq     <= 1'b0;
            wdt     <= 1'b0;
            strikes <= '0;
        end else begin
            irq <= hit && raises_irq(mode);
            wdt <= hit && ((mode == ACT_RST) || last_strike);
            if (!pend || (mode != ACT_IRQ_RST))
                strikes <= '0;
            else if (hit)
                strikes <= last_strike ? '0 : strikes + 1'b1;
        end
    end
endmodule

// File: rtl/mcw_core.sv
`timescale 1ns/1ps
module mcw_core
    import mcw_pkg::*;
#(
    parameter int  SW  = SHORT_W,
    parameter int  LW  = LONG_W,
    localparam int TBW = $clog2(LW)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2:0]     en_i,
    input  logic [2:0]     clr_i,
    input  logic [SW-1:0]  match0_i,
    input  logic [SW-1:0]  match1_i,
    input  logic [1:0]     clr_on_match_i,
    input  logic [1:0]     casc_i,
    input  logic [1:0]     mode0_i,
    input  logic [1:0]     mode1_i,
    input  logic           mode2_i,
    input  logic [TBW-1:0] tbit_i,
    input  logic [2:0]     pend_i,
    output logic [SW-1:0]  cnt0_o,
    output logic [SW-1:0]  cnt1_o,
    output logic [LW-1:0]  cnt2_o,
    output logic [2:0]     irq_o,
    output logic           wdt_rst_o,
    output logic [2:0]     en_stat_o
);
    logic [N_CTR-1:0] run, clr_now, tick, hit, wdt_each;
    ctr_evt_t         sevt [N_SHORT];
    logic [SW-1:0]    scnt [N_SHORT];
    logic [SW-1:0]    smatch [N_SHORT];
    act_mode_e        mode [N_CTR];

    mcw_sync #(.N(N_CTR)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .en_async(en_i),
        .clr_req (clr_i),
        .en_run  (run),
        .clr_now (clr_now)
    );

    assign smatch[0] = match0_i;
    assign smatch[1] = match1_i;
    assign mode[0]   = act_mode_e'(mode0_i);
    assign mode[1]   = act_mode_e'(mode1_i);
    assign mode[2]   = act_mode_e'({1'b0, mode2_i});

    // Counter 0 always takes the base clock; higher ones may take a carry.
    assign tick[0] = 1'b1;

    for (genvar i = 0; i < N_SHORT; i++) begin : g_short
        assign tick[i+1] = casc_i[i] ? sevt[i].carry : 1'b1;

        mcw_match_ctr #(.W(SW)) u_ctr (
            .clk         (clk),
            .rst         (rst),
            .run         (run[i]),
            .tick        (tick[i]),
            .clr         (clr_now[i]),
            .clr_on_match(clr_on_match_i[i]),
            .match       (smatch[i]),
            .cnt         (scnt[i]),
            .evt         (sevt[i])
        );
        assign hit[i] = sevt[i].hit;
    end

    mcw_toggle_ctr #(.W(LW)) u_long (
        .clk (clk),
        .rst (rst),
        .run (run[N_SHORT]),
        .tick(tick[N_SHORT]),
        .clr (clr_now[N_SHORT]),
        .sel (tbit_i),
        .cnt (cnt2_o),
        .hit (hit[N_SHORT])
    );

    for (genvar i = 0; i < N_CTR; i++) begin : g_act
        mcw_action #(.LIMIT(STRIKES)) u_act (
            .clk (clk),
            .rst (rst),
            .hit (hit[i]),
            .mode(mode[i]),
            .pend(pend_i[i]),
            .irq (irq_o[i]),
            .wdt (wdt_each[i])
        );
    end

    assign cnt0_o    = scnt[0];
    assign cnt1_o    = scnt[1];
    assign wdt_rst_o = |wdt_each;
    assign en_stat_o = run;
endmodule

// File: rtl/mcw_core_chk.sv
`timescale 1ns/1ps
module mcw_core_chk #(
    parameter int  SW  = 16,
    parameter int  LW  = 32,
    localparam int TBW = $clog2(LW)
) (
    input logic           clk,
    input logic           rst,
    input logic [2:0]     en_i,
    input logic [2:0]     clr_i,
    input logic [SW-1:0]  match0_i,
    input logic [SW-1:0]  match1_i,
    input logic [1:0]     clr_on_match_i,
    input logic [1:0]     casc_i,
    input logic [1:0]     mode0_i,
    input logic [1:0]     mode1_i,
    input logic           mode2_i,
    input logic [TBW-1:0] tbit_i,
    input logic [2:0]     pend_i,
    input logic [SW-1:0]  cnt0_o,
    input logic [SW-1:0]  cnt1_o,
    input logic [LW-1:0]  cnt2_o,
    input logic [2:0]     irq_o,
    input logic           wdt_rst_o,
    input logic [2:0]     en_stat_o
);
    // R2
    cnt0_step_chk: assert property (@(posedge clk) disable iff (rst)
        $past(en_stat_o[0]) |-> (cnt0_o == SW'($past(cnt0_o) + 1'b1)) || (cnt0_o == '0));

    // R1
    cnt0_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(en_stat_o[0]) |-> (cnt0_o == $past(cnt0_o)) || (cnt0_o == '0));

    // R2
    cnt0_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clr_i[0], 2) |-> (cnt0_o == '0));

    // R7
    irq0_mode_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o[0] |-> $past(mode0_i[0]));

    // R7
    irq2_mode_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o[2] |-> $past(mode2_i));

    // R9
    wdt_mode_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_o |-> ($past(mode0_i[1]) || $past(mode1_i[1])));
endmodule

bind mcw_core mcw_core_chk #(.SW(SW), .LW(LW)) u_chk (.*);

// File: tb/tb_mcw_core.sv
`timescale 1ns/1ps
module tb_mcw_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  en_i = '0, clr_i = '0, pend_i = '0, irq_o, en_stat_o;
    logic [15:0] match0_i = '0, match1_i = '0, cnt0_o, cnt1_o;
    logic [1:0]  clr_on_match_i = '0, casc_i = '0, mode0_i = '0, mode1_i = '0;
    logic        mode2_i = 1'b0, wdt_rst_o;
    logic [4:0]  tbit_i = '0;
    logic [31:0] cnt2_o;

    int n_tests = 0, n_fail = 0, cyc = 0, t0 = 0, tend = 0;
    bit sb_on = 1'b0;

    typedef struct { int at; int kind; string req; } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mcw_core dut (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int at, input int kind, input string req);
        exp_t e;
        e.at = at; e.kind = kind; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic wait_to(input int c);
        while (cyc != c) @(negedge clk);
    endtask

    // Monitor: every pulse must match the head of the expected queue
    always @(negedge clk) begin
        if (sb_on && cyc <= tend) begin
            for (int k = 0; k < 4; k++) begin
                logic b;
                b = (k < 3) ? irq_o[k] : wdt_rst_o;
                if (b) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "unexpected pulse", k, -1);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(e.at == cyc && e.kind == k, e.req, cyc * 10 + k, e.at * 10 + e.kind);
                    end
                end
            end
        end
    end

    task automatic go(input logic [2:0] m, input int w);
        t0 = cyc; tend = cyc + w; sb_on = 1'b1; en_i = m;
    endtask

    task automatic close_test(input string req);
        wait_to(tend + 1);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
        sb_on = 1'b0;
        mode0_i = '0; mode1_i = '0; mode2_i = 1'b0; pend_i = '0; en_i = '0;
        repeat (4) @(negedge clk);
        clr_i = 3'b111;
        @(negedge clk);
        clr_i = '0; casc_i = '0; clr_on_match_i = '0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(cnt0_o == 0 && cnt1_o == 0 && cnt2_o == 0, "R10 counts", cnt0_o + cnt1_o + cnt2_o, 0);
        chk(irq_o == 0 && wdt_rst_o == 0 && en_stat_o == 0, "R10 outputs", {irq_o, wdt_rst_o, en_stat_o}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // T1: clear-on-match, interrupt mode, enable latency (R1 R2 R4 R7)
        match0_i = 16'd4; clr_on_match_i = 2'b01; mode0_i = 2'd1;
        go(3'b001, 30);
        for (int k = 0; k < 5; k++) push(t0 + 7 + 5 * k, 0, "R4 irq0 period");
        wait_to(t0 + 1); chk(en_stat_o[0] == 1'b0, "R1 status one edge", en_stat_o[0], 0);
        wait_to(t0 + 2); chk(en_stat_o[0] == 1'b1, "R1 status two edges", en_stat_o[0], 1);
        chk(cnt0_o == 0, "R1 not counting yet", cnt0_o, 0);
        wait_to(t0 + 3); chk(cnt0_o == 1, "R2 first increment", cnt0_o, 1);
        wait_to(t0 + 9); chk(cnt0_o == 2, "R4 count restarted", cnt0_o, 2);
        close_test("R7 all irq0 pulses seen");

        // T2: clear request and disable latency (R1 R2)
        go(3'b001, 40);
        wait_to(t0 + 20); chk(cnt0_o == 18, "R2 free count", cnt0_o, 18);
        clr_i[0] = 1'b1;
        wait_to(t0 + 21); clr_i[0] = 1'b0;
        chk(cnt0_o == 19, "R2 clear not yet", cnt0_o, 19);
        wait_to(t0 + 22); chk(cnt0_o == 0, "R2 cleared", cnt0_o, 0);
        wait_to(t0 + 23); chk(cnt0_o == 1, "R2 counts after clear", cnt0_o, 1);
        en_i[0] = 1'b0;
        wait_to(t0 + 28); chk(cnt0_o == 3, "R1 stops two edges late", cnt0_o, 3);
        chk(en_stat_o[0] == 1'b0, "R1 status low", en_stat_o[0], 0);
        close_test("R2 no pulses");

        // T3: match cascade chain, reset mode, toggle on cascaded counter (R5 R6 R7 R9)
        match0_i = 16'd2; match1_i = 16'd1; clr_on_match_i = 2'b11; casc_i = 2'b11;
        mode1_i = 2'd2; mode2_i = 1'b1; tbit_i = 5'd1;
        go(3'b111, 30);
        push(t0 + 8, 3, "R9 reset mode pulse");
        push(t0 + 14, 2, "R6 cascaded toggle irq");
        push(t0 + 14, 3, "R9 reset mode pulse");
        push(t0 + 20, 3, "R9 reset mode pulse");
        push(t0 + 26, 2, "R6 cascaded toggle irq");
        push(t0 + 26, 3, "R9 reset mode pulse");
        wait_to(t0 + 6); chk(cnt1_o == 1, "R5 counter1 ticks on carry", cnt1_o, 1);
        wait_to(t0 + 15); chk(cnt2_o == 2, "R5 counter2 ticks on carry", cnt2_o, 2);
        close_test("R9 all cascade pulses seen");

        // T4: free-running wrap, wrap carry into counter 1 (R3 R5)
        match0_i = 16'd2; match1_i = 16'd0; casc_i = 2'b01;
        mode0_i = 2'd1; mode1_i = 2'd1;
        go(3'b011, 65545);
        push(t0 + 5, 0, "R3 first match");
        push(t0 + 65538, 1, "R5 wrap carry match");
        push(t0 + 65541, 0, "R3 match after full wrap");
        wait_to(t0 + 100);
        chk(cnt0_o == 98, "R3 counts past match", cnt0_o, 98);
        chk(cnt1_o == 0, "R5 counter1 held without carry", cnt1_o, 0);
        wait_to(t0 + 65538);
        chk(cnt0_o == 0, "R3 wrapped to zero", cnt0_o, 0);
        chk(cnt1_o == 1, "R5 one carry taken", cnt1_o, 1);
        close_test("R3 wrap pulses seen");

        // T5: toggle bit on base clock (R6)
        tbit_i = 5'd3; mode2_i = 1'b1;
        go(3'b100, 36);
        for (int k = 0; k < 4; k++) push(t0 + 10 + 8 * k, 2, "R6 toggle period");
        wait_to(t0 + 10); chk(cnt2_o == 8, "R6 count at toggle", cnt2_o, 8);
        close_test("R6 toggle pulses seen");

        // T6: three strikes, restart on serviced interrupt (R8 R7)
        match0_i = 16'd1; clr_on_match_i = 2'b01; mode0_i = 2'd3; pend_i[0] = 1'b1;
        go(3'b001, 19);
        for (int c = 4; c <= 18; c += 2) begin
            push(t0 + c, 0, "R7 mode3 irq");
            if (c == 8 || c == 18) push(t0 + c, 3, "R8 third strike");
        end
        wait_to(t0 + 11); pend_i[0] = 1'b0;
        wait_to(t0 + 12); pend_i[0] = 1'b1;
        close_test("R8 strike pulses seen");

        // T7: held and repeated clear on a cascaded counter (R2)
        match0_i = 16'd1; clr_on_match_i = 2'b01; casc_i = 2'b01;
        go(3'b011, 20);
        wait_to(t0 + 2); clr_i[1] = 1'b1;
        wait_to(t0 + 6); chk(cnt1_o == 0, "R2 held clear beats carry", cnt1_o, 0);
        wait_to(t0 + 12); chk(cnt1_o == 0, "R2 held clear beats carry", cnt1_o, 0);
        clr_i[1] = 1'b0;
        wait_to(t0 + 15); chk(cnt1_o == 1, "R2 resumes after clear", cnt1_o, 1);
        wait_to(t0 + 16); clr_i[1] = 1'b1;
        wait_to(t0 + 17); clr_i[1] = 1'b0;
        chk(cnt1_o == 2, "R2 carry before second clear", cnt1_o, 2);
        wait_to(t0 + 18); chk(cnt1_o == 0, "R2 second clear", cnt1_o, 0);
        close_test("R2 no pulses");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule